// File: doc/BRIEF.md
# Toggle-Loaded Random Access Scan Array

This block is a square grid of scan cells in which every cell can be reached on its own, so it can stand in for a serial scan chain. A test address is split into a row field and a column field. Each field drives a one-hot decoder. In functional mode every cell takes its combinational data bit on the system clock edge, as an ordinary register does.

In test mode the cells keep their values unless a toggle strobe arrives. The strobe inverts only the one cell whose row line and column line are both selected. No cell has a scan-in wire or a test-control wire. To set a cell to a required value, a pattern loader toggles it only when its current value differs from the target, and leaves it alone otherwise. Only the cells a given test needs are visited.

A readout output always carries the value of the cell named by the current address, in any mode. It feeds a separate scan-out tree. The cell count must be a power of four; the default of 16 cells gives a 4x4 grid with 2-bit row and column fields.

Top module: `ras_toggle_array`

## Requirements
- R1: A clock edge with `rst_n` low clears every cell to 0.
- R2: A clock edge with `func_en` high loads every cell from the matching bit of `func_d`, so `cell_q` equals `func_d` one cycle later.
- R3: While `func_en` is high, `tgl_stb` has no effect. The result of that edge is exactly `func_d`, with no cell inverted.
- R4: A clock edge with `func_en` low and `tgl_stb` high inverts exactly one cell, the one at bit position `row_addr*SIDE + col_addr` of `cell_q`, and leaves every other cell unchanged.
- R5: A clock edge with `func_en` low and `tgl_stb` low leaves every cell unchanged, whatever the address.
- R6: `rd_bit` equals bit `row_addr*SIDE + col_addr` of `cell_q` at all times, in both modes, and follows an address change with no clock edge.
- R7: Toggling each cell that differs from a target word, once each, leaves `cell_q` equal to the target. Toggling the same cell twice restores its original value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| func_en | input | 1 | High: functional capture; low: test mode |
| tgl_stb | input | 1 | Single-cycle toggle strobe for the addressed cell |
| row_addr | input | AW (2) | Row field of the test address |
| col_addr | input | AW (2) | Column field of the test address |
| func_d | input | CELLS (16) | Functional data, one bit per cell |
| cell_q | output | CELLS (16) | Stored cell values, bit r*SIDE+c is row r, column c |
| rd_bit | output | 1 | Value of the currently addressed cell |

## Verification
The assertions run on every cycle. They check that a functional edge loads the data word even when a strobe is present, that each test-mode strobe flips exactly one bit and that this bit is the addressed one, that test-mode cycles without a strobe hold every cell, and that the readout always matches the addressed cell. Only the bench scenarios can show that a whole target word is built by toggling the differing cells, that a double toggle restores a cell, and that reset in the middle of a run clears a non-zero array. The walk over every cell, including the corner addresses (0,0) and (3,3), is also bench-only.

// File: rtl/ras_pkg.sv
// Package: shared types and helpers for the random access scan array.
// Assumes cell counts are powers of four (square grid, power-of-two side).
package ras_pkg;

    // Action a single cell takes on a clock edge
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_CAPT = 2'd1,
        ACT_FLIP = 2'd2,
        ACT_CLR  = 2'd3
    } cell_act_e;

    // Width of one grid-side address field: half of log2(cells)
    function automatic int side_bits(input int cells);
        int b;
        b = 0;
        while ((1 << b) < cells) b++;
        return b / 2;
    endfunction

endpackage

// File: rtl/ras_onehot_dec.sv
// Module: one-hot line decoder for one grid dimension.
// Drives exactly one line high when enabled, all lines low otherwise.
// Assumes the address is always in range (2**AW lines).
module ras_onehot_dec #(
    parameter int AW    = 2,
    localparam int LINES = 1 << AW
) (
    input  logic             en,
    input  logic [AW-1:0]    addr,
    output logic [LINES-1:0] ln
);

    genvar i;
    generate
        for (i = 0; i < LINES; i++) begin : g_line
            // One line: high when enabled and the address names it
            assign ln[i] = en && (addr == AW'(i));
        end
    endgenerate

endmodule

// File: rtl/ras_cell.sv
// Module: one toggle-loaded scan cell.
// Captures func_d in functional mode; in test mode inverts only when the
// strobe meets both its row and column lines. Functional capture wins.
module ras_cell
    import ras_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic func_en,
    input  logic func_d,
    input  logic row_ln,
    input  logic col_ln,
    input  logic tgl_pulse,
    output logic q
);

    cell_act_e act;

    // Pick the action for this edge, in priority order
    always_comb begin
        if (!rst_n)
            act = ACT_CLR;
        else if (func_en)
            act = ACT_CAPT;
        else if (tgl_pulse && row_ln && col_ln)
            act = ACT_FLIP;
        else
            act = ACT_HOLD;
    end

    // Storage element updated by the chosen action
    always_ff @(posedge clk) begin
        case (act)
            ACT_CLR:  q <= 1'b0;
            ACT_CAPT: q <= func_d;
            ACT_FLIP: q <= ~q;
            default:  q <= q;
        endcase
    end

endmodule

// File: rtl/ras_readout.sv
// Module: readout selector for the addressed cell.
// Picks a row word by row address, then a bit by column address.
// Purely combinational; works in any mode.
module ras_readout #(
    parameter int AW    = 2,
    localparam int SIDE = 1 << AW,
    localparam int CELLS = SIDE * SIDE
) (
    input  logic [CELLS-1:0] cells,
    input  logic [AW-1:0]    row_addr,
    input  logic [AW-1:0]    col_addr,
    output logic             rd_bit
);

    logic [SIDE-1:0] row_word [SIDE];
    logic [SIDE-1:0] sel_row;

    genvar r;
    generate
        for (r = 0; r < SIDE; r++) begin : g_row
            // Slice one row of the grid out of the flat cell vector
            assign row_word[r] = cells[r*SIDE +: SIDE];
        end
    endgenerate

    // Two-level selection: row word, then column bit
    always_comb begin
        sel_row = row_word[row_addr];
        rd_bit  = sel_row[col_addr];
    end

endmodule

// File: rtl/ras_toggle_array.sv
// Module: top of the toggle-loaded random access scan array.
// Decoders are enabled only in test mode; their lines plus a shared strobe
// reach each cell. No scan-in or test-control wire goes to any cell.
// Assumes CELLS is a power of four.
module ras_toggle_array
    import ras_pkg::*;
#(
    parameter int CELLS = 16,
    localparam int AW   = side_bits(CELLS),
    localparam int SIDE = 1 << AW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             func_en,
    input  logic             tgl_stb,
    input  logic [AW-1:0]    row_addr,
    input  logic [AW-1:0]    col_addr,
    input  logic [CELLS-1:0] func_d,
    output logic [CELLS-1:0] cell_q,
    output logic             rd_bit
);

    logic            test_mode;
    logic            tgl_pulse;
    logic [SIDE-1:0] row_ln;
    logic [SIDE-1:0] col_ln;

    // Test mode is simply the absence of functional mode
    assign test_mode = ~func_en;
    // Strobe reaches cells only in test mode
    assign tgl_pulse = tgl_stb & test_mode;

    ras_onehot_dec #(.AW(AW)) u_row_dec (
        .en   (test_mode),
        .addr (row_addr),
        .ln   (row_ln)
    );

    ras_onehot_dec #(.AW(AW)) u_col_dec (
        .en   (test_mode),
        .addr (col_addr),
        .ln   (col_ln)
    );

    genvar r, c;
    generate
        for (r = 0; r < SIDE; r++) begin : g_r
            for (c = 0; c < SIDE; c++) begin : g_c
                ras_cell u_cell (
                    .clk       (clk),
                    .rst_n     (rst_n),
                    .func_en   (func_en),
                    .func_d    (func_d[r*SIDE + c]),
                    .row_ln    (row_ln[r]),
                    .col_ln    (col_ln[c]),
                    .tgl_pulse (tgl_pulse),
                    .q         (cell_q[r*SIDE + c])
                );
            end
        end
    endgenerate

    ras_readout #(.AW(AW)) u_rd (
        .cells    (cell_q),
        .row_addr (row_addr),
        .col_addr (col_addr),
        .rd_bit   (rd_bit)
    );

endmodule

// File: rtl/ras_toggle_array_chk.sv
// Module: assertion checker bound to ras_toggle_array.
// Observes ports only and checks the cycle rules of the array.
module ras_toggle_array_chk #(
    parameter int CELLS = 16,
    parameter int AW    = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             func_en,
    input logic             tgl_stb,
    input logic [AW-1:0]    row_addr,
    input logic [AW-1:0]    col_addr,
    input logic [CELLS-1:0] func_d,
    input logic [CELLS-1:0] cell_q,
    input logic             rd_bit
);

    logic [2*AW-1:0] idx;
    assign idx = {row_addr, col_addr};

    // R2: functional edge loads the data word
    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        func_en |=> cell_q == $past(func_d));

    // R3: strobe in functional mode changes nothing beyond the capture
    a_r3_func_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (func_en && tgl_stb) |=> cell_q == $past(func_d));

    // R4: a test-mode strobe flips exactly one cell
    a_r4_single_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (!func_en && tgl_stb) |=> $countones(cell_q ^ $past(cell_q)) == 1);

    // R4: the flipped cell is the addressed one
    a_r4_addr_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (!func_en && tgl_stb) |=> cell_q[$past(idx)] != $past(cell_q[idx]));

    // R5: test mode without a strobe holds every cell
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!func_en && !tgl_stb) |=> $stable(cell_q));

    // R6: readout matches the addressed cell
    a_r6_readout: assert property (@(posedge clk) disable iff (!rst_n)
        rd_bit == cell_q[idx]);

endmodule

bind ras_toggle_array ras_toggle_array_chk #(.CELLS(CELLS), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .func_en  (func_en),
    .tgl_stb  (tgl_stb),
    .row_addr (row_addr),
    .col_addr (col_addr),
    .func_d   (func_d),
    .cell_q   (cell_q),
    .rd_bit   (rd_bit)
);

// File: tb/ras_toggle_array_tb.sv
// Scoreboard bench: the driver pushes expected results, the monitor pops
// and compares them just after each clock edge.
module ras_toggle_array_tb;

    localparam int CELLS = 16;
    localparam int AW    = 2;
    localparam int SIDE  = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             func_en = 1'b0;
    logic             tgl_stb = 1'b0;
    logic [AW-1:0]    row_addr = '0;
    logic [AW-1:0]    col_addr = '0;
    logic [CELLS-1:0] func_d = '0;
    logic [CELLS-1:0] cell_q;
    logic             rd_bit;

    typedef struct {
        logic [CELLS-1:0] st;
        logic             rd;
        string            tag;
    } exp_t;

    exp_t             sb_q[$];
    logic [CELLS-1:0] model = '0;
    int               n_run = 0;
    int               n_fail = 0;
    bit               done = 0;

    ras_toggle_array #(.CELLS(CELLS)) u_dut (
        .clk(clk), .rst_n(rst_n), .func_en(func_en), .tgl_stb(tgl_stb),
        .row_addr(row_addr), .col_addr(col_addr), .func_d(func_d),
        .cell_q(cell_q), .rd_bit(rd_bit)
    );

    always #10 clk = ~clk;

    // Driver: apply one cycle of stimulus and push the expected outcome
    task automatic drive(input bit rst, input bit fe, input bit stb,
                         input int r, input int c,
                         input logic [CELLS-1:0] d, input string tag);
        exp_t e;
        @(negedge clk);
        rst_n = rst; func_en = fe; tgl_stb = stb;
        row_addr = AW'(r); col_addr = AW'(c); func_d = d;
        if (!rst)      model = '0;
        else if (fe)   model = d;
        else if (stb)  model[r*SIDE + c] = ~model[r*SIDE + c];
        e.st = model; e.rd = model[r*SIDE + c]; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compare just after each edge, away from the edge itself
    always @(posedge clk) begin
        exp_t e;
        #2;
        if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            n_run++;
            if (cell_q !== e.st || rd_bit !== e.rd) begin
                n_fail++;
                $display("FAIL %s: cell_q=%h rd=%b expected cell_q=%h rd=%b",
                         e.tag, cell_q, rd_bit, e.st, e.rd);
            end
        end
    end

    // Target load by toggling only the differing cells
    task automatic load_target(input logic [CELLS-1:0] tgt);
        for (int i = 0; i < CELLS; i++)
            if (model[i] != tgt[i]) drive(1, 0, 1, i / SIDE, i % SIDE, '0, "R7");
        drive(1, 0, 0, 1, 2, '1, "R7");
        @(negedge clk);
        n_run++;
        if (model !== tgt) begin
            n_fail++;
            $display("FAIL R7: model=%h expected %h", model, tgt);
        end
    endtask

    initial begin
        // R1 reset with noisy inputs
        drive(0, 1, 1, 3, 3, 16'hFFFF, "R1");
        drive(0, 0, 1, 2, 1, 16'hA5A5, "R1");
        // R2 functional capture, several patterns
        drive(1, 1, 0, 0, 0, 16'hA5C3, "R2");
        drive(1, 1, 0, 3, 3, 16'h0F0F, "R2");
        drive(1, 1, 0, 2, 1, 16'hFFFF, "R2");
        drive(1, 1, 0, 1, 3, 16'h0000, "R2");
        // R3 strobe ignored in functional mode
        drive(1, 1, 1, 1, 1, 16'h1234, "R3");
        drive(1, 1, 1, 3, 0, 16'h1234, "R3");
        // R5 hold with strobe low, assorted addresses and data
        drive(1, 0, 0, 0, 0, 16'hFFFF, "R5");
        drive(1, 0, 0, 3, 3, 16'h0000, "R5");
        drive(1, 0, 0, 2, 2, 16'hBEEF, "R5");
        // R4 walk every cell, corners included
        for (int i = 0; i < CELLS; i++) drive(1, 0, 1, i / SIDE, i % SIDE, 16'h5555, "R4");
        // R6 readout sweep in test mode, then in functional mode
        for (int i = 0; i < CELLS; i++) drive(1, 0, 0, i / SIDE, i % SIDE, '0, "R6");
        drive(1, 1, 0, 2, 3, 16'h8000, "R6");
        drive(1, 1, 0, 3, 3, 16'h8000, "R6");
        // R7 double toggle restores
        drive(1, 0, 1, 2, 1, '0, "R7");
        drive(1, 0, 1, 2, 1, '0, "R7");
        // R7 target loads
        load_target(16'hC3A5);
        load_target(16'h0001);
        load_target(16'hFFFE);
        // R1 reset from a non-zero state
        drive(0, 0, 0, 1, 1, '0, "R1");
        drive(1, 0, 0, 1, 1, '0, "R1");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule